// File: doc/BRIEF.md
# Host Request Pin Generator

This block sits on the host side of a parallel host-to-processor port and produces the request pins that the external host (or its DMA controller) watches. The host writes four control bits into a small register: a receive request enable, a transmit request enable, a split-pin select and a general-purpose host flag. The block combines those bits with the DSP-side mode inputs and with the receive-full and transmit-empty status flags, and drives either one combined request pin or a separate transmit and receive request pin.

The same two enable bits mean different things in different modes. In interrupt mode they choose which status conditions raise a request. In DMA mode they choose the transfer direction. The split-pin select turns the second pin from an acknowledge input into a dedicated receive request. The host flag passes through to the DSP side as a read-only status bit.

Top module: `host_req_unit`

## Requirements
- R1: After reset, every control bit is clear, both request pins are high (inactive), `ack_seen` is 0 and `host_flag` is 0.
- R2: Interrupt mode applies when `dma_mode` is 000 or `host_mode` is 00. In interrupt mode a transmit request exists when `tx_empty` is 1 and control bit 1 (transmit enable) is set. A receive request exists when `rx_full` is 1 and control bit 0 (receive enable) is set. With both enables clear, no request ever exists.
- R3: In DMA mode with `dma_mode` equal to 100, the enable pair {bit1, bit0} selects the direction. 10 gives a transmit request on `tx_empty`. 01 gives a receive request on `rx_full`. 00 and the reserved 11 give no request.
- R4: In DMA mode with any other `dma_mode`, the transmit enable has no effect and no transmit request exists. A receive request exists when bit 0 is set and `rx_full` is 1.
- R5: With control bit 2 (split select) clear, `req_a_n` is low exactly when a transmit or receive request exists, and `req_b_n` stays high.
- R6: With control bit 2 set, `req_a_n` is low only for a transmit request and `req_b_n` is low only for a receive request.
- R7: With bit 2 clear, `ack_seen` shows `ack_in` as sampled at the previous clock edge. With bit 2 set, `ack_seen` is 0.
- R8: `host_flag` equals control bit 3 as last written by the host. It changes only on a host write.
- R9: The request pins are registered. A status or mode input change shows on the pins after one clock edge. A control write takes effect in the register at its edge and shows on the pins at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the control register |
| wr_data | input | 4 | Control value: bit0 rx enable, bit1 tx enable, bit2 split select, bit3 host flag |
| dma_mode | input | 3 | DSP-side DMA mode field |
| host_mode | input | 2 | Host mode field; 00 forces interrupt mode |
| rx_full | input | 1 | Receive data register full |
| tx_empty | input | 1 | Transmit data register empty |
| ack_in | input | 1 | Acknowledge input, used while split select is clear |
| req_a_n | output | 1 | Combined request, or transmit request when split (active low) |
| req_b_n | output | 1 | Receive request when split, else held high (active low) |
| ack_seen | output | 1 | Sampled acknowledge |
| host_flag | output | 1 | Host flag seen by the DSP side |

## Verification
A corrupted control bit shows on the pins one edge after the write that should have set it. It appears as a request that is missing or spurious for some combination of mode and status flags. A wrong mode decode shows as a pin that does not match its expected value on the edge after the offending mode is applied. For this reason the bench sweeps every control value against every mode and status combination and samples each pin one edge after the stimulus changes. The reserved DMA combination and the ignored transmit enable are checked directly at the pins, since any leakage there shows up as a low request.

// File: rtl/host_req_pkg.sv
package host_req_pkg;
    localparam int CTRL_W    = 4;
    localparam int BIT_RXEN  = 0;
    localparam int BIT_TXEN  = 1;
    localparam int BIT_SPLIT = 2;
    localparam int BIT_FLAG  = 3;

    typedef struct packed {
        logic flag;
        logic split;
        logic txen;
        logic rxen;
    } ctrl_t;

    typedef struct packed {
        logic tx;
        logic rx;
    } req_t;

    typedef struct packed {
        logic req_a_n;
        logic req_b_n;
        logic ack;
    } pin_state_t;
endpackage

// File: rtl/host_ctrl_reg.sv
module host_ctrl_reg
    import host_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.rxen  = wr_data[BIT_RXEN];
            ctrl_d.txen  = wr_data[BIT_TXEN];
            ctrl_d.split = wr_data[BIT_SPLIT];
            ctrl_d.flag  = wr_data[BIT_FLAG];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/host_req_decode.sv
module host_req_decode
    import host_req_pkg::*;
#(
    parameter int          DMA_W      = 3,
    parameter int          HMODE_W    = 2,
    parameter logic [2:0]  SPLIT_CODE = 3'b100
) (
    input  ctrl_t              ctrl_q,
    input  logic [DMA_W-1:0]   dma_mode,
    input  logic [HMODE_W-1:0] host_mode,
    input  logic               rx_full,
    input  logic               tx_empty,
    output req_t               req
);
    logic irq_mode;
    logic dir_mode;

    assign irq_mode = (dma_mode == '0) || (host_mode == '0);
    assign dir_mode = (dma_mode == DMA_W'(SPLIT_CODE));

    always_comb begin
        req = '0;
        if (irq_mode) begin
            req.tx = ctrl_q.txen & tx_empty;
            req.rx = ctrl_q.rxen & rx_full;
        end else if (dir_mode) begin
            unique case ({ctrl_q.txen, ctrl_q.rxen})
                2'b10:   req.tx = tx_empty;
                2'b01:   req.rx = rx_full;
                default: req   = '0;
            endcase
        end else begin
            req.rx = ctrl_q.rxen & rx_full;
        end
    end
endmodule

// File: rtl/host_req_pins.sv
module host_req_pins
    import host_req_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_q,
    input  req_t  req,
    input  logic  ack_in,
    output logic  pin_a,
    output logic  pin_b,
    output logic  ack_q
);
    pin_state_t st_d, st_q;
    localparam logic IDLE = ACTIVE_LOW;

    always_comb begin
        st_d = st_q;
        if (ctrl_q.split) begin
            st_d.req_a_n = req.tx ? ~IDLE : IDLE;
            st_d.req_b_n = req.rx ? ~IDLE : IDLE;
            st_d.ack     = 1'b0;
        end else begin
            st_d.req_a_n = (req.tx | req.rx) ? ~IDLE : IDLE;
            st_d.req_b_n = IDLE;
            st_d.ack     = ack_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req_a_n <= IDLE;
            st_q.req_b_n <= IDLE;
            st_q.ack     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign pin_a = st_q.req_a_n;
            assign pin_b = st_q.req_b_n;
        end else begin : g_high
            assign pin_a = st_q.req_a_n;
            assign pin_b = st_q.req_b_n;
        end
    endgenerate
    assign ack_q = st_q.ack;
endmodule

// File: rtl/host_req_unit.sv
module host_req_unit
    import host_req_pkg::*;
#(
    parameter int DMA_W   = 3,
    parameter int HMODE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTRL_W-1:0]  wr_data,
    input  logic [DMA_W-1:0]   dma_mode,
    input  logic [HMODE_W-1:0] host_mode,
    input  logic               rx_full,
    input  logic               tx_empty,
    input  logic               ack_in,
    output logic               req_a_n,
    output logic               req_b_n,
    output logic               ack_seen,
    output logic               host_flag
);
    ctrl_t ctrl_q;
    req_t  req;

    host_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q)
    );

    host_req_decode #(.DMA_W(DMA_W), .HMODE_W(HMODE_W)) u_dec (
        .ctrl_q(ctrl_q), .dma_mode(dma_mode), .host_mode(host_mode),
        .rx_full(rx_full), .tx_empty(tx_empty), .req(req)
    );

    host_req_pins #(.ACTIVE_LOW(1'b1)) u_pins (
        .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .req(req), .ack_in(ack_in),
        .pin_a(req_a_n), .pin_b(req_b_n), .ack_q(ack_seen)
    );

    assign host_flag = ctrl_q.flag;
endmodule

// File: rtl/host_req_chk.sv
module host_req_chk
    import host_req_pkg::*;
#(
    parameter int DMA_W   = 3,
    parameter int HMODE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input ctrl_t              ctrl_q,
    input logic [DMA_W-1:0]   dma_mode,
    input logic [HMODE_W-1:0] host_mode,
    input logic               tx_empty,
    input logic               req_a_n,
    input logic               req_b_n,
    input logic               ack_seen,
    input logic               host_flag
);
    logic irq_mode;
    assign irq_mode = (dma_mode == '0) || (host_mode == '0);

    // R2
    polling_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode && !ctrl_q.txen && !ctrl_q.rxen) |=> (req_a_n && req_b_n));

    // R3
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_mode && dma_mode == 3'b100 && ctrl_q.txen && ctrl_q.rxen)
        |=> (req_a_n && req_b_n));

    // R5
    single_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.split |=> req_b_n);

    // R6
    split_tx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.split && !tx_empty) |=> req_a_n);

    // R7
    split_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.split |=> !ack_seen);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(host_flag));
endmodule

bind host_req_unit host_req_chk #(.DMA_W(DMA_W), .HMODE_W(HMODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_q(ctrl_q),
    .dma_mode(dma_mode), .host_mode(host_mode), .tx_empty(tx_empty),
    .req_a_n(req_a_n), .req_b_n(req_b_n), .ack_seen(ack_seen), .host_flag(host_flag)
);

// File: tb/host_req_unit_test.sv
module host_req_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [2:0] dma_mode = '0;
    logic [1:0] host_mode = '0;
    logic       rx_full = 1'b0, tx_empty = 1'b0, ack_in = 1'b0;
    logic       req_a_n, req_b_n, ack_seen, host_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_req_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dma_mode(dma_mode), .host_mode(host_mode), .rx_full(rx_full),
        .tx_empty(tx_empty), .ack_in(ack_in), .req_a_n(req_a_n),
        .req_b_n(req_b_n), .ack_seen(ack_seen), .host_flag(host_flag)
    );

    task automatic check(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(logic [3:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // expected active-high requests: {tx, rx}
    function automatic logic [1:0] exp_req(logic [3:0] c, logic [2:0] dm,
                                           logic [1:0] hm, logic rf, logic te);
        logic rxe, txe;
        rxe = c[0]; txe = c[1];
        if (dm == 3'd0 || hm == 2'd0) return {txe & te, rxe & rf};   // R2
        if (dm == 3'd4) begin                                         // R3
            if (txe && !rxe) return {te, 1'b0};
            if (!txe && rxe) return {1'b0, rf};
            return 2'b00;
        end
        return {1'b0, rxe & rf};                                      // R4
    endfunction

    initial begin
        #(200000 * CLK_PERIOD);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 req_a_n", req_a_n, 1'b1);
        check("R1 req_b_n", req_b_n, 1'b1);
        check("R1 ack_seen", ack_seen, 1'b0);
        check("R1 host_flag", host_flag, 1'b0);
        rst_n = 1'b1;

        // R9 control write latency: irq mode, rx_full, write rx enable
        @(negedge clk);
        rx_full = 1'b1;
        wr_en = 1'b1; wr_data = 4'b0001;
        @(posedge clk); #1;
        check("R9 pin after write edge", req_a_n, 1'b1);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        check("R9 pin one edge later", req_a_n, 1'b0);
        // R9 status latency
        @(negedge clk); rx_full = 1'b0;
        #1 check("R9 before edge", req_a_n, 1'b0);
        @(posedge clk); #1;
        check("R9 status after edge", req_a_n, 1'b1);

        // exhaustive sweep: R2 R3 R4 R5 R6 R7 R8
        for (int c = 0; c < 16; c++) begin
            write_ctrl(4'(c));
            check("R8 host_flag", host_flag, c[3]);
            for (int m = 0; m < 32; m++) begin
                for (int s = 0; s < 8; s++) begin
                    logic [1:0] e;
                    @(negedge clk);
                    dma_mode = m[2:0]; host_mode = m[4:3];
                    rx_full = s[0]; tx_empty = s[1]; ack_in = s[2];
                    e = exp_req(4'(c), m[2:0], m[4:3], s[0], s[1]);
                    @(posedge clk); #1;
                    if (c[2]) begin
                        check("R6 req_a_n split", req_a_n, ~e[1]);
                        check("R6 req_b_n split", req_b_n, ~e[0]);
                        check("R7 ack forced 0", ack_seen, 1'b0);
                    end else begin
                        check("R5 req_a_n combined", req_a_n, ~(e[1] | e[0]));
                        check("R5 req_b_n idle", req_b_n, 1'b1);
                        check("R7 ack sampled", ack_seen, s[2]);
                    end
                end
            end
            check("R8 flag unchanged", host_flag, c[3]);
        end

        // R3 reserved with both status flags set, split pins
        write_ctrl(4'b0111);
        @(negedge clk); dma_mode = 3'd4; host_mode = 2'd1; rx_full = 1; tx_empty = 1;
        @(posedge clk); #1;
        check("R3 reserved a", req_a_n, 1'b1);
        check("R3 reserved b", req_b_n, 1'b1);
        // R4 tx enable ignored in other DMA codes
        write_ctrl(4'b0110);
        @(negedge clk); dma_mode = 3'd5; host_mode = 2'd2;
        @(posedge clk); #1;
        check("R4 tx ignored", req_a_n, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule